// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block places a 64x64 hardware cursor on top of a raster pixel stream. Each cycle the video pipeline presents the current screen coordinate and the pixel that lies underneath. One cycle later the block returns one of three things: that pixel unchanged, one of two programmable cursor colours, or the bitwise complement of the pixel. A small internal image store, filled through a write port, holds the cursor picture at two bits per pixel. Software sets the on-screen position, the image start word and two preset offsets. With these offsets a cursor can hang partly over the left or top edge while the position stays non-negative.

The vertical preset only shortens how many rows are shown. To skip rows at the top of the image, software moves the image start word forward by two per skipped row, because a row holds 16 bytes and the start word counts 8-byte units. The horizontal preset picks the first image column shown. The two cursor colours are double-buffered and only take effect at a frame-start pulse, so a colour change never tears in the middle of a frame.

Top module: `cur_overlay`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pix_out` is 0, the cursor is disabled and every register is cleared.
- R2: The cursor is shown only while bit 7 of the control register (select 5) is 1. When that bit is 0, `pix_out` equals the previous cycle's `pix_in`, and clearing it hides the cursor from the next pixel on.
- R3: A visible pixel with code 00 outputs the active colour 0 (select 0). A visible pixel with code 01 outputs the active colour 1 (select 1).
- R4: A visible pixel with code 10 is transparent: the output is `pix_in`.
- R5: A visible pixel with code 11 outputs the bitwise complement of `pix_in`.
- R6: The position register (select 3) holds Y in bits 31:16 and X in bits 15:0. The preset register (select 4) holds the vertical preset V in bits 21:16 and the horizontal preset H in bits 5:0. With dx = pix_x - X and dy = pix_y - Y, the pixel is visible only if dx >= 0, dy >= 0, dx + H < 64 and dy + V < 64.
- R7: The image column is col = dx + H. The code is read from word base + 2*dy + col/32, at bits 2*(col%32)+1 : 2*(col%32).
- R8: The image start register (select 2) counts 64-bit words (8 bytes). Adding 2n to it moves the displayed image down by n rows of 16 bytes.
- R9: Writes to the colour registers take effect only at a `frame_start` pulse. Pixels before the pulse keep the old colours.
- R10: `pix_out` is registered and reflects the inputs of the previous clock cycle.
- R11: `img_we` writes the 64-bit `img_wdata` into image word `img_addr`. Later pixels that map to that word use the new codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 colour 0, 1 colour 1, 2 image start, 3 position, 4 presets, 5 control |
| reg_wdata | input | 32 | Register write data |
| img_we | input | 1 | Image store write strobe |
| img_addr | input | 8 | Image store word address |
| img_wdata | input | 64 | Image word (32 pixels, 2 bits each) |
| frame_start | input | 1 | Pulse that loads pending colours |
| pix_x | input | 16 | Current screen column |
| pix_y | input | 16 | Current screen row |
| pix_in | input | 8 | Underlying pixel |
| pix_out | output | 8 | Overlaid pixel, one cycle later |

## Verification
The bench builds the block with its default parameters: 8-bit pixels, 16-bit coordinates, a 64-pixel cursor and a 256-word image store. With these defaults all 64 rows of the image fit in the store at any start word the bench uses. Both 32-pixel halves of a row can be reached, so the column, row, preset and start-word arithmetic can be checked against an image pattern whose code depends on word and lane. The stored image varies along both axes, so all four codes and both window edges show up at distinct expected values.

// File: rtl/cur_pkg.sv
package cur_pkg;

  typedef enum logic [1:0] {
    CODE_COL0   = 2'b00,
    CODE_COL1   = 2'b01,
    CODE_CLEAR  = 2'b10,
    CODE_INVERT = 2'b11
  } cur_code_e;

  typedef enum logic [2:0] {
    SEL_COL0   = 3'd0,
    SEL_COL1   = 3'd1,
    SEL_BASE   = 3'd2,
    SEL_POS    = 3'd3,
    SEL_PRESET = 3'd4,
    SEL_CTRL   = 3'd5
  } cur_sel_e;

  localparam int EN_BIT = 7;

  // Window test: offsets from the cursor origin, plus the presets, stay inside the array.
  function automatic logic in_window(int sx, int sy, int px, int py,
                                     int oh, int ov, int dim);
    return (sx >= px) && (sy >= py) &&
           ((sx - px + oh) < dim) && ((sy - py + ov) < dim);
  endfunction

endpackage

// File: rtl/cur_regs.sv
module cur_regs #(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 16,
  parameter int OW      = 6,
  parameter int AW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  input  logic               frame_start,
  output logic [PIX_W-1:0]   col0_live,
  output logic [PIX_W-1:0]   col1_live,
  output logic [AW-1:0]      base,
  output logic [COORD_W-1:0] pos_x,
  output logic [COORD_W-1:0] pos_y,
  output logic [OW-1:0]      off_h,
  output logic [OW-1:0]      off_v,
  output logic               cur_en
);
  import cur_pkg::*;

  logic [PIX_W-1:0] col0_pend, col1_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col0_pend <= '0;
      col1_pend <= '0;
      base      <= '0;
      pos_x     <= '0;
      pos_y     <= '0;
      off_h     <= '0;
      off_v     <= '0;
      cur_en    <= 1'b0;
    end else if (reg_we) begin
      case (cur_sel_e'(reg_sel))
        SEL_COL0:   col0_pend <= reg_wdata[PIX_W-1:0];
        SEL_COL1:   col1_pend <= reg_wdata[PIX_W-1:0];
        SEL_BASE:   base      <= reg_wdata[AW-1:0];
        SEL_POS: begin
          pos_x <= reg_wdata[COORD_W-1:0];
          pos_y <= reg_wdata[16 +: COORD_W];
        end
        SEL_PRESET: begin
          off_h <= reg_wdata[OW-1:0];
          off_v <= reg_wdata[16 +: OW];
        end
        SEL_CTRL:   cur_en <= reg_wdata[EN_BIT];
        default: ;
      endcase
    end
  end

  // Colours in use change only at a frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col0_live <= '0;
      col1_live <= '0;
    end else if (frame_start) begin
      col0_live <= col0_pend;
      col1_live <= col1_pend;
    end
  end

endmodule

// File: rtl/cur_img_ram.sv
module cur_img_ram #(
  parameter int WORDS  = 256,
  parameter int WORD_W = 64,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cur_locate.sv
module cur_locate #(
  parameter int COORD_W = 16,
  parameter int CUR_DIM = 64,
  parameter int PPW     = 32,
  parameter int OW      = 6,
  parameter int AW      = 8,
  localparam int LW     = $clog2(PPW),
  localparam int RW     = CUR_DIM / PPW
) (
  input  logic               cur_en,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic [OW-1:0]      off_h,
  input  logic [OW-1:0]      off_v,
  input  logic [AW-1:0]      base,
  output logic               hit,
  output logic [AW-1:0]      rd_addr,
  output logic [LW-1:0]      lane
);
  import cur_pkg::*;

  logic [COORD_W-1:0] row, col;

  always_comb begin
    row     = pix_y - pos_y;
    col     = pix_x - pos_x + COORD_W'(off_h);
    hit     = cur_en && in_window(int'(pix_x), int'(pix_y), int'(pos_x),
                                  int'(pos_y), int'(off_h), int'(off_v), CUR_DIM);
    rd_addr = base + AW'(row * RW) + AW'(col >> LW);
    lane    = col[LW-1:0];
  end

endmodule

// File: rtl/cur_overlay.sv
module cur_overlay #(
  parameter int PIX_W     = 8,
  parameter int COORD_W   = 16,
  parameter int CUR_DIM   = 64,
  parameter int MEM_WORDS = 256,
  localparam int WORD_W   = 64,
  localparam int PPW      = WORD_W / 2,
  localparam int LW       = $clog2(PPW),
  localparam int OW       = $clog2(CUR_DIM),
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  input  logic               img_we,
  input  logic [AW-1:0]      img_addr,
  input  logic [WORD_W-1:0]  img_wdata,
  input  logic               frame_start,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [PIX_W-1:0]   pix_in,
  output logic [PIX_W-1:0]   pix_out
);
  import cur_pkg::*;

  logic [PIX_W-1:0]   col0_live, col1_live;
  logic [AW-1:0]      base, rd_addr;
  logic [COORD_W-1:0] pos_x, pos_y;
  logic [OW-1:0]      off_h, off_v;
  logic               cur_en, cur_hit;
  logic [LW-1:0]      lane;
  logic [WORD_W-1:0]  rd_word;
  cur_code_e          cur_code;

  cur_regs #(.PIX_W(PIX_W), .COORD_W(COORD_W), .OW(OW), .AW(AW)) u_regs (
    .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .frame_start,
    .col0_live, .col1_live, .base, .pos_x, .pos_y, .off_h, .off_v, .cur_en
  );

  cur_locate #(.COORD_W(COORD_W), .CUR_DIM(CUR_DIM), .PPW(PPW), .OW(OW), .AW(AW)) u_loc (
    .cur_en, .pix_x, .pix_y, .pos_x, .pos_y, .off_h, .off_v, .base,
    .hit(cur_hit), .rd_addr, .lane
  );

  cur_img_ram #(.WORDS(MEM_WORDS), .WORD_W(WORD_W)) u_ram (
    .clk, .we(img_we), .waddr(img_addr), .wdata(img_wdata),
    .raddr(rd_addr), .rdata(rd_word)
  );

  assign cur_code = cur_code_e'(rd_word[{lane, 1'b0} +: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out <= '0;
    end else if (!cur_hit) begin
      pix_out <= pix_in;
    end else begin
      case (cur_code)
        CODE_COL0:   pix_out <= col0_live;
        CODE_COL1:   pix_out <= col1_live;
        CODE_CLEAR:  pix_out <= pix_in;
        CODE_INVERT: pix_out <= ~pix_in;
        default:     pix_out <= pix_in;
      endcase
    end
  end

endmodule

// File: rtl/cur_overlay_chk.sv
module cur_overlay_chk #(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic [COORD_W-1:0] pix_x,
  input logic [COORD_W-1:0] pos_x,
  input logic [PIX_W-1:0]   pix_in,
  input logic [PIX_W-1:0]   pix_out,
  input logic               cur_en,
  input logic               cur_hit,
  input logic [1:0]         cur_code,
  input logic [PIX_W-1:0]   col0_live,
  input logic [PIX_W-1:0]   col1_live
);
  assert_hidden_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_en |=> pix_out == $past(pix_in));

  assert_colour0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_hit && cur_code == 2'b00) |=> pix_out == $past(col0_live));

  assert_colour1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_hit && cur_code == 2'b01) |=> pix_out == $past(col1_live));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_hit && cur_code == 2'b10) |=> pix_out == $past(pix_in));

  assert_invert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_hit && cur_code == 2'b11) |=> pix_out == ~$past(pix_in));

  assert_left_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x < pos_x) |-> !cur_hit);

  assert_frame_colours_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(col0_live) && $stable(col1_live)));

endmodule

bind cur_overlay cur_overlay_chk #(.PIX_W(PIX_W), .COORD_W(COORD_W)) u_chk (
  .clk, .rst_n, .frame_start, .pix_x, .pos_x, .pix_in, .pix_out,
  .cur_en, .cur_hit, .cur_code, .col0_live, .col1_live
);

// File: tb/test_cur_overlay.sv
`timescale 1ns/1ps
module test_cur_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        img_we = 1'b0;
  logic [7:0]  img_addr = '0;
  logic [63:0] img_wdata = '0;
  logic        frame_start = 1'b0;
  logic [15:0] pix_x = '0, pix_y = '0;
  logic [7:0]  pix_in = '0;
  logic [7:0]  pix_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cur_overlay i_cur_overlay (
    .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .img_we, .img_addr,
    .img_wdata, .frame_start, .pix_x, .pix_y, .pix_in, .pix_out
  );

  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
    logic [7:0]  pin;
    logic [7:0]  exp;
  } vec_t;

  // Cursor at X=100, Y=50, no presets, start word 0, colours 11/22.
  // Stored code of lane i in word w is (w + i) mod 4.
  localparam vec_t VECS [12] = '{
    '{16'd100, 16'd50,  8'h5A, 8'h11},  // R3 code 00
    '{16'd101, 16'd50,  8'h5A, 8'h22},  // R3 code 01
    '{16'd102, 16'd50,  8'h5A, 8'h5A},  // R4 code 10
    '{16'd103, 16'd50,  8'h5A, 8'hA5},  // R5 code 11
    '{16'd99,  16'd50,  8'h5A, 8'h5A},  // R6 left of cursor
    '{16'd100, 16'd49,  8'h5A, 8'h5A},  // R6 above cursor
    '{16'd163, 16'd50,  8'h5A, 8'h11},  // R7 last column
    '{16'd164, 16'd50,  8'h5A, 8'h5A},  // R6 right of cursor
    '{16'd132, 16'd50,  8'h5A, 8'h22},  // R7 second word of row
    '{16'd100, 16'd51,  8'h3C, 8'h3C},  // R7 row 1
    '{16'd101, 16'd113, 8'h0F, 8'hF0},  // R7 last row
    '{16'd100, 16'd114, 8'h5A, 8'h5A}   // R6 below cursor
  };

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] sel, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wr_img(logic [7:0] a, logic [63:0] d);
    @(negedge clk); img_we = 1'b1; img_addr = a; img_wdata = d;
    @(negedge clk); img_we = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  // R10: drive at a falling edge, read after exactly one rising edge.
  task automatic pixel(logic [15:0] x, logic [15:0] y, logic [7:0] p,
                       output logic [7:0] got);
    @(negedge clk); pix_x = x; pix_y = y; pix_in = p;
    @(negedge clk); got = pix_out;
  endtask

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    check("R1 reset output", pix_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle after reset", pix_out, 8'h00);

    for (int w = 0; w < 256; w++) begin
      logic [63:0] d;
      for (int i = 0; i < 32; i++) d[2*i +: 2] = 2'((w + i) % 4);
      wr_img(8'(w), d);
    end
    wr_reg(3'd3, {16'd50, 16'd100});
    wr_reg(3'd0, 32'h11);
    wr_reg(3'd1, 32'h22);
    pulse_frame();

    pixel(16'd100, 16'd50, 8'h5A, got);
    check("R2 disabled passes pixel", got, 8'h5A);

    wr_reg(3'd5, 32'h80);
    foreach (VECS[k]) begin
      pixel(VECS[k].x, VECS[k].y, VECS[k].pin, got);
      check($sformatf("R6/R7 table entry %0d", k), got, VECS[k].exp);
    end

    // Presets H=48, V=48.
    wr_reg(3'd4, {16'd48, 16'd48});
    pixel(16'd100, 16'd50, 8'h5A, got);
    check("R7 horizontal preset first column", got, 8'h22);
    pixel(16'd115, 16'd50, 8'h5A, got);
    check("R7 preset last column", got, 8'h11);
    pixel(16'd116, 16'd50, 8'h5A, got);
    check("R6 preset shrinks width", got, 8'h5A);
    pixel(16'd100, 16'd65, 8'h5A, got);
    check("R6 preset last visible row", got, 8'hA5);
    pixel(16'd100, 16'd66, 8'h5A, got);
    check("R6 preset shrinks height", got, 8'h5A);
    wr_reg(3'd4, 32'h0);

    // Start word moves.
    wr_reg(3'd2, 32'd1);
    pixel(16'd100, 16'd50, 8'h5A, got);
    check("R8 start word 1", got, 8'h22);
    wr_reg(3'd2, 32'd3);
    pixel(16'd100, 16'd50, 8'h5A, got);
    check("R8 start advanced by 2 skips a row", got, 8'hA5);
    wr_reg(3'd2, 32'd0);

    // Colour change waits for frame_start.
    wr_reg(3'd0, 32'h77);
    pixel(16'd100, 16'd50, 8'h5A, got);
    check("R9 colour held mid-frame", got, 8'h11);
    pulse_frame();
    pixel(16'd100, 16'd50, 8'h5A, got);
    check("R9 colour after frame start", got, 8'h77);

    // Rewrite word 0 as all invert codes.
    wr_img(8'd0, '1);
    pixel(16'd101, 16'd50, 8'h5A, got);
    check("R11 rewritten image word", got, 8'hA5);

    wr_reg(3'd5, 32'h0);
    pixel(16'd100, 16'd50, 8'h5A, got);
    check("R2 cleared enable hides cursor", got, 8'h5A);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule